// File: doc/BRIEF.md
# Four-Channel Buffered PWM Generator

This block produces four independent pulse-width modulated outputs. Software programs it through a small register port with an address, write data, a write strobe, a read strobe and combinational read data. A shared free-running divider supplies prescaled ticks to every channel. Each channel counts those ticks over a programmable period. Its output sits at the idle level for the first `duty` ticks of every period and at the active level for the rest.

Each channel runs a small state machine with three states:

- **CH_OFF**: the channel is disabled.
- **CH_REST**: the channel is enabled and the counter is below the duty value, so the output is at the idle level.
- **CH_DRIVE**: the channel is enabled and the counter is at or above the duty value, so the output is at the active level.

The transitions between them are:

- **start**: CH_OFF goes to CH_REST or CH_DRIVE on an enable write.
- **reach**: CH_REST goes to CH_DRIVE when the counter meets the duty value.
- **wrap**: CH_DRIVE goes to CH_REST when the counter returns to zero with a non-zero duty.
- **stop**: any running state goes to CH_OFF on a disable write.

While a channel runs, a new duty or period is written to its update register. That value is copied into the working register only when the period ends, so the waveform never shows a partial period. A sticky per-channel end-of-period flag lets software confirm that a transfer has happened before it disables the channel.

Top module: `pwm_bank`

## Requirements
- R1: A write to 0x04 starts every channel whose data bit (bits 3..0) is one. A write to 0x08 stops every such channel. Zero bits leave channels unchanged. A read of 0x0C returns the running state in bits 3..0, and all channels are stopped after reset.
- R2: The event register at 0x1C has bit i set when channel i ends a period. The whole register clears when it is read. An end of period in the same cycle as that read stays set.
- R3: Channel i occupies 0x200 + 0x20*i. The fields are: mode at +0x00, duty at +0x04, duty update at +0x08, period at +0x0C, period update at +0x10. All of them read back, and mode reads back with the prescaler in bits 3..0 and polarity in bit 9. Reads of any other offset return zero.
- R4: Mode bits 3..0 select N, and the channel counts once every 2^N clock cycles for N in 0..10. For N of 11..15 the counter does not advance and no period ends.
- R5: Mode bit 9 is the idle level. The active level is its inverse. A stopped channel drives the idle level.
- R6: Duty, period and both update registers keep only write-data bits 15..0.
- R7: While a channel is stopped, duty and period writes take effect at once. While it runs, direct duty and period writes are ignored.
- R8: The counter runs 0 to period-1 and then wraps. A period of 0 behaves as a period of 1. The output is active while the counter is at or above duty, giving period-duty active ticks per period, or none when duty is at least the period.
- R9: An update-register write marks a pending value, and a later write before the wrap replaces it. At the wrap the pending value becomes the working duty or period. Until then the working value is unchanged.
- R10: Stopping a channel clears its counter. After a start with N=0 and period P, the first end of period comes P cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe; an event read clears at the edge |
| reg_rdata | output | 32 | Read data, valid while reg_re is high |
| pwm_out | output | 4 | Channel waveforms |

## Verification
Two things can land on the same clock edge: a period end setting an event bit, and a read of the event register clearing it. The bench reads the event register every cycle while a channel runs with a short period, so some reads must coincide with a wrap edge. It then measures the number of cycles between successive sightings of the bit. Every gap must equal the period times the prescale factor; a set lost to the clear would double a gap. The same gap measurement also checks the prescaler and the counter restart after a start.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_REST  = 2'd1,
        CH_DRIVE = 2'd2
    } ch_state_e;

    // global register offsets
    localparam int OFS_ENA  = 'h04;
    localparam int OFS_DIS  = 'h08;
    localparam int OFS_STAT = 'h0C;
    localparam int OFS_EVT  = 'h1C;

    // offsets inside one channel window
    localparam int FLD_MODE = 'h00;
    localparam int FLD_DUTY = 'h04;
    localparam int FLD_DUPD = 'h08;
    localparam int FLD_PRD  = 'h0C;
    localparam int FLD_PUPD = 'h10;

    // mode field: polarity bit position
    localparam int POL_BIT  = 9;

endpackage

// File: rtl/pwm_bank_tick.sv
module pwm_bank_tick #(
    parameter int MAX_EXP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [MAX_EXP:0] tick_vec
);

    logic [MAX_EXP-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + MAX_EXP'(1);
        end
    end

    // tap k fires once every 2^k cycles
    generate
        for (genvar k = 0; k <= MAX_EXP; k++) begin : g_tap
            if (k == 0) begin : g_every
                assign tick_vec[k] = 1'b1;
            end else begin : g_div
                assign tick_vec[k] = &div_q[k-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRES_W  = 4,
    parameter int MAX_EXP = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_EXP:0]  tick_vec,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mode_we,
    input  logic [PRES_W-1:0] pres_wval,
    input  logic              pol_wval,
    input  logic              duty_we,
    input  logic              dupd_we,
    input  logic              prd_we,
    input  logic              pupd_we,
    input  logic [CNT_W-1:0]  wval,
    output logic              en_o,
    output logic              wrap_o,
    output logic              pwm_o,
    output logic              pol_o,
    output logic [PRES_W-1:0] pres_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  dupd_o,
    output logic [CNT_W-1:0]  prd_o,
    output logic [CNT_W-1:0]  pupd_o,
    output logic              dpend_o
);

    localparam int SEL_N = 2 ** PRES_W;

    ch_state_e         state_q, state_n, phase_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [CNT_W-1:0]  duty_q, duty_n, dupd_q, dupd_n;
    logic [CNT_W-1:0]  prd_q, prd_n, pupd_q, pupd_n;
    logic              dpend_q, dpend_n, ppend_q, ppend_n;
    logic [PRES_W-1:0] pres_q;
    logic              pol_q;

    logic [SEL_N-1:0]  tick_pad;
    logic              tick_sel, running, at_last, wrap;
    logic [CNT_W:0]    cnt_inc;

    // prescaler select: taps above MAX_EXP stay zero, freezing the counter
    always_comb begin
        tick_pad              = '0;
        tick_pad[MAX_EXP:0]   = tick_vec;
    end
    assign tick_sel = tick_pad[pres_q];

    assign running  = (state_q != CH_OFF);
    assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign at_last  = (cnt_inc >= {1'b0, prd_q});
    assign wrap     = running && tick_sel && at_last;

    // working and buffered values
    always_comb begin
        duty_n  = duty_q;
        prd_n   = prd_q;
        dupd_n  = dupd_q;
        pupd_n  = pupd_q;
        dpend_n = dpend_q;
        ppend_n = ppend_q;

        if (wrap && dpend_q) begin
            duty_n = dupd_q;
        end else if (!running && duty_we) begin
            duty_n = wval;
        end

        if (wrap && ppend_q) begin
            prd_n = pupd_q;
        end else if (!running && prd_we) begin
            prd_n = wval;
        end

        if (dupd_we) begin
            dupd_n  = wval;
            dpend_n = 1'b1;
        end else if (wrap) begin
            dpend_n = 1'b0;
        end

        if (pupd_we) begin
            pupd_n  = wval;
            ppend_n = 1'b1;
        end else if (wrap) begin
            ppend_n = 1'b0;
        end
    end

    // counter
    always_comb begin
        cnt_n = cnt_q;
        if (!running || en_clr) begin
            cnt_n = '0;
        end else if (tick_sel) begin
            cnt_n = at_last ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

    // next state
    always_comb begin
        phase_n = (cnt_n >= duty_n) ? CH_DRIVE : CH_REST;
        unique case (state_q)
            CH_OFF:            state_n = en_set ? phase_n : CH_OFF;
            CH_REST, CH_DRIVE: state_n = en_clr ? CH_OFF : phase_n;
            default:           state_n = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            duty_q  <= '0;
            dupd_q  <= '0;
            prd_q   <= '0;
            pupd_q  <= '0;
            dpend_q <= 1'b0;
            ppend_q <= 1'b0;
            pres_q  <= '0;
            pol_q   <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            duty_q  <= duty_n;
            dupd_q  <= dupd_n;
            prd_q   <= prd_n;
            pupd_q  <= pupd_n;
            dpend_q <= dpend_n;
            ppend_q <= ppend_n;
            if (mode_we) begin
                pres_q <= pres_wval;
                pol_q  <= pol_wval;
            end
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            CH_DRIVE: pwm_o = ~pol_q;
            default:  pwm_o = pol_q;
        endcase
    end

    assign en_o    = running;
    assign wrap_o  = wrap;
    assign pol_o   = pol_q;
    assign pres_o  = pres_q;
    assign duty_o  = duty_q;
    assign dupd_o  = dupd_q;
    assign prd_o   = prd_q;
    assign pupd_o  = pupd_q;
    assign dpend_o = dpend_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int PRES_W    = 4,
    parameter int MAX_EXP   = 10,
    parameter int CH_BASE   = 'h200,
    parameter int CH_STRIDE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int STRIDE_LOG = $clog2(CH_STRIDE);
    localparam int CH_IDX_W   = $clog2(NUM_CH);
    localparam int WIN_END    = CH_BASE + NUM_CH * CH_STRIDE;

    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(WIN_END);

    logic [MAX_EXP:0]                tick_vec;
    logic [NUM_CH-1:0]               en_vec, wrap_vec, pol_vec, dpend_vec;
    logic [NUM_CH-1:0]               en_set_vec, en_clr_vec, dupd_we_vec;
    logic [NUM_CH-1:0][PRES_W-1:0]   pres_arr;
    logic [NUM_CH-1:0][CNT_W-1:0]    duty_arr, dupd_arr, prd_arr, pupd_arr;
    logic [NUM_CH-1:0]               ev_q;

    logic                  in_win, we_ena, we_dis, ev_clr;
    logic [ADDR_W-1:0]     rel;
    logic [CH_IDX_W-1:0]   ch_idx;
    logic [STRIDE_LOG-1:0] fld;
    logic                  unused_bits;

    // address decode
    assign in_win = (reg_addr >= A_BASE) && (reg_addr < A_END);
    assign rel    = reg_addr - A_BASE;
    assign ch_idx = rel[STRIDE_LOG +: CH_IDX_W];
    assign fld    = rel[STRIDE_LOG-1:0];
    assign we_ena = reg_we && (reg_addr == A_ENA);
    assign we_dis = reg_we && (reg_addr == A_DIS);
    assign ev_clr = reg_re && (reg_addr == A_EVT);

    assign unused_bits = ^{reg_wdata[DATA_W-1:CNT_W], rel[ADDR_W-1:STRIDE_LOG+CH_IDX_W]};

    pwm_bank_tick #(
        .MAX_EXP (MAX_EXP)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_vec (tick_vec)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic hit, we_mode, we_duty, we_prd, we_pupd;

            assign hit            = in_win && (ch_idx == CH_IDX_W'(i));
            assign we_mode        = reg_we && hit && (fld == STRIDE_LOG'(FLD_MODE));
            assign we_duty        = reg_we && hit && (fld == STRIDE_LOG'(FLD_DUTY));
            assign dupd_we_vec[i] = reg_we && hit && (fld == STRIDE_LOG'(FLD_DUPD));
            assign we_prd         = reg_we && hit && (fld == STRIDE_LOG'(FLD_PRD));
            assign we_pupd        = reg_we && hit && (fld == STRIDE_LOG'(FLD_PUPD));
            assign en_set_vec[i]  = we_ena && reg_wdata[i];
            assign en_clr_vec[i]  = we_dis && reg_wdata[i];

            pwm_bank_chan #(
                .CNT_W   (CNT_W),
                .PRES_W  (PRES_W),
                .MAX_EXP (MAX_EXP)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_vec  (tick_vec),
                .en_set    (en_set_vec[i]),
                .en_clr    (en_clr_vec[i]),
                .mode_we   (we_mode),
                .pres_wval (reg_wdata[PRES_W-1:0]),
                .pol_wval  (reg_wdata[POL_BIT]),
                .duty_we   (we_duty),
                .dupd_we   (dupd_we_vec[i]),
                .prd_we    (we_prd),
                .pupd_we   (we_pupd),
                .wval      (reg_wdata[CNT_W-1:0]),
                .en_o      (en_vec[i]),
                .wrap_o    (wrap_vec[i]),
                .pwm_o     (pwm_out[i]),
                .pol_o     (pol_vec[i]),
                .pres_o    (pres_arr[i]),
                .duty_o    (duty_arr[i]),
                .dupd_o    (dupd_arr[i]),
                .prd_o     (prd_arr[i]),
                .pupd_o    (pupd_arr[i]),
                .dpend_o   (dpend_vec[i])
            );
        end
    endgenerate

    // event register: a period end beats a same-cycle read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= (ev_q & ~{NUM_CH{ev_clr}}) | wrap_vec;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            if (reg_addr == A_STAT) begin
                reg_rdata[NUM_CH-1:0] = en_vec;
            end else if (reg_addr == A_EVT) begin
                reg_rdata[NUM_CH-1:0] = ev_q;
            end else if (in_win) begin
                unique case (int'(fld))
                    FLD_MODE: begin
                        reg_rdata[PRES_W-1:0] = pres_arr[ch_idx];
                        reg_rdata[POL_BIT]    = pol_vec[ch_idx];
                    end
                    FLD_DUTY: reg_rdata[CNT_W-1:0] = duty_arr[ch_idx];
                    FLD_DUPD: reg_rdata[CNT_W-1:0] = dupd_arr[ch_idx];
                    FLD_PRD:  reg_rdata[CNT_W-1:0] = prd_arr[ch_idx];
                    FLD_PUPD: reg_rdata[CNT_W-1:0] = pupd_arr[ch_idx];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic                           reg_re,
    input logic [NUM_CH-1:0]              en_vec,
    input logic [NUM_CH-1:0]              wrap_vec,
    input logic [NUM_CH-1:0]              ev_q,
    input logic [NUM_CH-1:0]              dpend_vec,
    input logic [NUM_CH-1:0]              dupd_we_vec,
    input logic [NUM_CH-1:0]              pol_vec,
    input logic [NUM_CH-1:0]              pwm_out,
    input logic [NUM_CH-1:0][CNT_W-1:0]   duty_arr
);

    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(OFS_EVT);

    // R2
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == A_EVT) |=> ((ev_q & ~$past(wrap_vec)) == '0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_c
            // R5
            idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !en_vec[i] |-> (pwm_out[i] == pol_vec[i]));
            // R2
            evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wrap_vec[i] |=> ev_q[i]);
            // R9
            pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wrap_vec[i] && !dupd_we_vec[i]) |=> !dpend_vec[i]);
            // R9
            duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en_vec[i] && !wrap_vec[i]) |=> $stable(duty_arr[i]));
        end
    endgenerate

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_re      (reg_re),
    .en_vec      (en_vec),
    .wrap_vec    (wrap_vec),
    .ev_q        (ev_q),
    .dpend_vec   (dpend_vec),
    .dupd_we_vec (dupd_we_vec),
    .pol_vec     (pol_vec),
    .pwm_out     (pwm_out),
    .duty_arr    (duty_arr)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_ENA  = 12'h004;
    localparam logic [11:0] A_DIS  = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_EVT  = 12'h01C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [11:0] cb(input int ch, input int fld);
        return 12'(32'h200 + ch * 32'h20 + fld);
    endfunction

    function automatic int exp_active(input int prd, input int duty, input int n, input int m);
        if (duty >= prd) return 0;
        return (prd - duty) * (1 << n) * m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // reads the event register every cycle; returns reads done until bit ch seen
    task automatic wait_evt(input int ch, output int c);
        logic [31:0] d;
        c = 0;
        do begin
            rd(A_EVT, d);
            c++;
        end while (!d[ch] && c < 5000);
    endtask

    task automatic measure(input int ch, input logic act, input int win, output int c);
        c = 0;
        for (int k = 0; k < win; k++) begin
            if (pwm_out[ch] == act) c++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int c;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 reset state
        chk("R5 reset idle low", 32'(pwm_out), 32'h0);
        rd(A_STAT, d); chk("R1 reset status", d, 32'h0);

        // R6 R3 readback while stopped
        wr(cb(1, 'hC), 32'hABCD_1234);
        rd(cb(1, 'hC), d); chk("R6 period low half", d, 32'h1234);
        wr(cb(2, 'h0), 32'hFFFF_FFFF);
        wr(cb(2, 'h4), 32'h0001_0011);
        wr(cb(2, 'h8), 32'h0000_0022);
        wr(cb(2, 'hC), 32'h0000_0033);
        wr(cb(2, 'h10), 32'hFFFF_0044);
        rd(cb(2, 'h0), d);  chk("R3 mode readback", d, 32'h20F);
        rd(cb(2, 'h4), d);  chk("R3 R7 duty readback", d, 32'h11);
        rd(cb(2, 'h8), d);  chk("R3 duty update readback", d, 32'h22);
        rd(cb(2, 'hC), d);  chk("R3 R7 period readback", d, 32'h33);
        rd(cb(2, 'h10), d); chk("R3 R6 period update readback", d, 32'h44);
        rd(12'h100, d);     chk("R3 unmapped global", d, 32'h0);
        rd(12'h214, d);     chk("R3 unmapped field", d, 32'h0);
        rd(12'h280, d);     chk("R3 past last channel", d, 32'h0);

        // R1 start / stop bit masks
        wr(A_ENA, 32'h5); rd(A_STAT, d); chk("R1 start mask", d, 32'h5);
        wr(A_ENA, 32'h0); rd(A_STAT, d); chk("R1 zero start bits", d, 32'h5);
        wr(A_DIS, 32'h4); rd(A_STAT, d); chk("R1 stop mask", d, 32'h1);
        wr(A_DIS, 32'hF); rd(A_STAT, d); chk("R1 stop all", d, 32'h0);

        // R10 R8: period 6, duty 2, divide by 1 on channel 0
        wr(cb(0, 'h0), 32'h0);
        wr(cb(0, 'hC), 32'd6);
        wr(cb(0, 'h4), 32'd2);
        rd(A_EVT, d);
        wr(A_ENA, 32'h1);
        wait_evt(0, c); chk("R10 first period end after start", 32'(c), 32'd7);
        // R2 same-cycle set and clear: gaps must equal the period
        for (int k = 0; k < 3; k++) begin
            wait_evt(0, c); chk("R2 event gap", 32'(c), 32'd6);
        end

        // R7 direct writes ignored while running
        wr(cb(0, 'h4), 32'd3);
        rd(cb(0, 'h4), d); chk("R7 duty write ignored", d, 32'd2);
        wr(cb(0, 'hC), 32'd9);
        rd(cb(0, 'hC), d); chk("R7 period write ignored", d, 32'd6);

        // R9 buffered duty: last write wins, applied at wrap
        wait_evt(0, c);
        wr(cb(0, 'h8), 32'd4);
        wr(cb(0, 'h8), 32'd5);
        rd(cb(0, 'h4), d); chk("R9 duty held until wrap", d, 32'd2);
        wait_evt(0, c);
        rd(cb(0, 'h4), d); chk("R9 last update applied", d, 32'd5);
        repeat (6) @(negedge clk);
        measure(0, 1'b1, 12, c); chk("R8 active after update", 32'(c), 32'(exp_active(6, 5, 0, 2)));
        rd(A_EVT, d);
        wr(cb(0, 'h10), 32'd10);
        wait_evt(0, c);
        rd(cb(0, 'hC), d); chk("R9 period update applied", d, 32'd10);

        // R2 clear on read, R5 idle level when stopped
        wr(A_DIS, 32'h1);
        rd(A_EVT, d);
        rd(A_EVT, d); chk("R2 cleared by read", d & 32'h1, 32'h0);
        chk("R5 stopped idle low", 32'(pwm_out[0]), 32'h0);
        wr(cb(0, 'h0), 32'h200);
        chk("R5 stopped idle high", 32'(pwm_out[0]), 32'h1);

        // R4 prescaler 2^2 with period 5 on channel 3
        wr(cb(3, 'h0), 32'd2);
        wr(cb(3, 'hC), 32'd5);
        wr(cb(3, 'h4), 32'd1);
        wr(A_ENA, 32'h8);
        wait_evt(3, c);
        wait_evt(3, c); chk("R4 divide by 4 gap", 32'(c), 32'd20);
        wait_evt(3, c); chk("R4 divide by 4 gap", 32'(c), 32'd20);
        wr(cb(3, 'h0), 32'd12);
        rd(A_EVT, d);
        repeat (200) @(negedge clk);
        rd(A_EVT, d); chk("R4 out-of-range prescaler frozen", d & 32'h8, 32'h0);
        wr(A_DIS, 32'hF);

        // R8 R5 random waveforms
        for (int t = 0; t < 16; t++) begin
            int ch, prd, duty, n;
            logic pol;
            ch   = $urandom_range(3, 0);
            prd  = $urandom_range(30, 1);
            duty = $urandom_range(prd + 2, 0);
            n    = $urandom_range(2, 0);
            pol  = 1'($urandom_range(1, 0));
            wr(cb(ch, 'h0), (32'(pol) << 9) | 32'(n));
            wr(cb(ch, 'hC), 32'(prd));
            wr(cb(ch, 'h4), 32'(duty));
            wr(cb(ch, 'h8), 32'(duty));
            wr(cb(ch, 'h10), 32'(prd));
            wr(A_ENA, 32'(1) << ch);
            repeat ((prd + 1) << n) @(negedge clk);
            measure(ch, ~pol, (2 * prd) << n, c);
            chk("R8 active cycles", 32'(c), 32'(exp_active(prd, duty, n, 2)));
            wr(A_DIS, 32'(1) << ch);
            chk("R5 idle after stop", 32'(pwm_out[ch]), 32'(pol));
        end

        finish_run();
    end

endmodule